// File: doc/BRIEF.md
# Triple Down-Counter Timer with Watchdog

This peripheral holds three 32-bit down-counters behind a word-addressed register bus: a tick timer (index 0), an auxiliary timer (index 1) and a watchdog (index 2). Each counter has its own reload register. One control word decides, per counter, whether it runs and whether it reloads itself on reaching zero. A counter that counts down to zero raises a sticky pending flag. The `irq` output is the OR of all pending flags. The watchdog's flag also drives a reset request, but only while the external `rst_out_en` input is high.

Software can overwrite a counter at any time, even while it runs. For the watchdog, such a write is the kick that restarts its countdown. Writing zero to the control word halts every counter and so disables the watchdog. The bus has no data streams. Writes are single-cycle strobes and are never stalled. `bus_rdata` is a combinational function of `bus_addr`, so the bus needs no valid/ready handshake and applies no back-pressure.

Top module: `tri_countdown_timer`

## Requirements
- R1: After reset, every counter, reload register, the control word and all pending flags read zero, and `irq`, `irq_pend` and `wd_reset_req` are low.
- R2: The control word at address 0 holds, for counter i, a run bit at position 2i and an auto-reload bit at position 2i+1. A write to the control word takes effect from the clock edge after the one that stores it. A running counter above zero drops by exactly one per clock. A stopped counter holds its value.
- R3: A running counter at zero with its auto-reload bit set loads its reload register on the next edge, which gives a period of reload+1 cycles.
- R4: A running counter at zero with its auto-reload bit clear stays at zero (one-shot).
- R5: When a running counter steps from 1 to 0, pending bit i (address 10, bits 2:0) is set on that same edge. A clear in the same cycle does not suppress the set. `irq` is high while any pending bit is set, and `irq_pend` shows the three bits.
- R6: Writing address 10 clears each pending bit whose write-data bit is 1 and leaves the others unchanged.
- R7: Counter i sits at address 5+2i and its reload register at 4+2i. Both read back their live values. A bus write to a counter replaces its value on that edge, taking priority over a decrement or a reload. For the watchdog, this write restarts the countdown.
- R8: Writing zero to the control word stops all three counters. From then on their values stay fixed.
- R9: `wd_reset_req` is high exactly while watchdog pending bit 2 is set and `rst_out_en` is high.
- R10: Addresses 1–3 and 11–15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters step on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (4) | Word address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| rst_out_en | input | 1 | Allows the watchdog to assert its reset request |
| irq | output | 1 | OR of all pending flags |
| irq_pend | output | 3 | Pending flags per counter |
| wd_reset_req | output | 1 | Watchdog reset request |

## Verification
On every cycle, assertions check the counter step rules. These cover a one-per-clock decrement, holding while stopped, reload at zero, sticking at zero in one-shot mode and bus writes overriding. They also check that an expiry sets its pending flag, that the reset request follows `rst_out_en` after a watchdog expiry, and that reserved writes and a zeroed control word leave state untouched. Only the directed scenarios show the exact expiry cycle seen at the pins, the reload+1 period, a watchdog kick postponing expiry, write-one-to-clear selectivity and the read-back values of the register map.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  localparam int NUM_CNT       = 3;
  localparam int CTRL_W        = 2 * NUM_CNT;
  localparam int WORD_CTRL     = 0;
  localparam int WORD_CNT_BASE = 4;   // reload at base+2i, counter at base+2i+1
  localparam int WORD_STAT     = 10;
  localparam int IDX_TICK      = 0;
  localparam int IDX_AUX       = 1;
  localparam int IDX_WD        = 2;
endpackage

// File: rtl/tcw_counter.sv
module tcw_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         auto_rl,
  input  logic         rl_wr,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rl_q,
  output logic [W-1:0] cnt_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)     rl_q <= '0;
    else if (rl_wr) rl_q <= wdata;
  end

  // Expiry is the 1 -> 0 step of a running counter that no bus write overrides.
  always_comb expire = run && !cnt_wr && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (cnt_wr)          cnt_q <= wdata;
    else if (run) begin
      if (cnt_q != '0)        cnt_q <= cnt_q - ONE;
      else if (auto_rl)       cnt_q <= rl_q;
    end
  end

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_reload_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && auto_rl && !cnt_wr && cnt_q == '0) |=> (cnt_q == $past(rl_q)));

  assert_oneshot_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !auto_rl && !cnt_wr && cnt_q == '0) |=> (cnt_q == '0));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/tcw_pending.sv
module tcw_pending #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend
);
  logic [N-1:0] clr_eff;

  always_comb clr_eff = clr_wr ? clr_mask : '0;

  // A new expiry outranks a clear landing in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_eff) | set;
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chk
      assert_set_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set[i] |=> pend[i]);
      assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[i] && !set[i]) |=> !pend[i]);
      assert_no_stray_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[i] && !(clr_wr && clr_mask[i])) |=> pend[i]);
    end
  endgenerate
endmodule

// File: rtl/tri_countdown_timer.sv
module tri_countdown_timer
  import tcw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rst_out_en,
  output logic              irq,
  output logic [NUM_CNT-1:0] irq_pend,
  output logic              wd_reset_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WORD_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WORD_STAT);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  rl_arr  [NUM_CNT];
  logic [DATA_W-1:0]  cnt_arr [NUM_CNT];
  logic [NUM_CNT-1:0] expire;
  logic               stat_wr;
  logic               addr_reserved;

  always_ff @(posedge clk) begin
    if (!rst_n)                            ctrl_q <= '0;
    else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  genvar i;
  generate
    for (i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam logic [ADDR_W-1:0] A_RL  = ADDR_W'(WORD_CNT_BASE + 2 * i);
      localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(WORD_CNT_BASE + 2 * i + 1);
      tcw_counter #(.W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q[2*i]),
        .auto_rl (ctrl_q[2*i+1]),
        .rl_wr   (bus_wr && bus_addr == A_RL),
        .cnt_wr  (bus_wr && bus_addr == A_CNT),
        .wdata   (bus_wdata),
        .rl_q    (rl_arr[i]),
        .cnt_q   (cnt_arr[i]),
        .expire  (expire[i])
      );
    end
  endgenerate

  always_comb stat_wr = bus_wr && bus_addr == A_STAT;

  tcw_pending #(.N(NUM_CNT)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (expire),
    .clr_wr   (stat_wr),
    .clr_mask (bus_wdata[NUM_CNT-1:0]),
    .pend     (irq_pend)
  );

  always_comb irq          = |irq_pend;
  always_comb wd_reset_req = irq_pend[IDX_WD] && rst_out_en;

  always_comb begin
    bus_rdata     = '0;
    addr_reserved = 1'b1;
    if (bus_addr == A_CTRL) begin
      bus_rdata[CTRL_W-1:0] = ctrl_q;
      addr_reserved         = 1'b0;
    end
    if (bus_addr == A_STAT) begin
      bus_rdata[NUM_CNT-1:0] = irq_pend;
      addr_reserved          = 1'b0;
    end
    for (int k = 0; k < NUM_CNT; k++) begin
      if (bus_addr == ADDR_W'(WORD_CNT_BASE + 2 * k)) begin
        bus_rdata     = rl_arr[k];
        addr_reserved = 1'b0;
      end
      if (bus_addr == ADDR_W'(WORD_CNT_BASE + 2 * k + 1)) begin
        bus_rdata     = cnt_arr[k];
        addr_reserved = 1'b0;
      end
    end
  end

  assert_wd_req_follows_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire[IDX_WD] |=> (wd_reset_req == rst_out_en));

  assert_all_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == '0 && !bus_wr) |=>
      ($stable(cnt_arr[IDX_TICK]) && $stable(cnt_arr[IDX_AUX]) && $stable(cnt_arr[IDX_WD])));

  assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && addr_reserved) |=> ($stable(ctrl_q) && $stable(rl_arr[IDX_TICK]) &&
      $stable(rl_arr[IDX_AUX]) && $stable(rl_arr[IDX_WD])));

  assert_reserved_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reserved |-> (bus_rdata == '0));
endmodule

// File: tb/tri_countdown_timer_tb.sv
module tri_countdown_timer_tb;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_RL0  = 4'd4;
  localparam logic [3:0] A_T0   = 4'd5;
  localparam logic [3:0] A_T1   = 4'd7;
  localparam logic [3:0] A_RL1  = 4'd6;
  localparam logic [3:0] A_TW   = 4'd9;
  localparam logic [3:0] A_STAT = 4'd10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_out_en = 1'b0;
  logic        irq;
  logic [2:0]  irq_pend;
  logic        wd_reset_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  tri_countdown_timer u_dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .rst_out_en (rst_out_en),
    .irq (irq), .irq_pend (irq_pend), .wd_reset_req (wd_reset_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write is stored at the next posedge; returns at the following negedge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_T0, v);   chk("R1 timer0", v, 0);
    rd(A_RL1, v);  chk("R1 reload1", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 reset req", {31'd0, wd_reset_req}, 0);
    step(1);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(A_T0, 5);
    wr(A_CTRL, 32'h1);          // run timer0, one-shot
    rd(A_T0, v); chk("R2 first value after enable", v, 5);
    step(1); rd(A_T0, v); chk("R2 decrement", v, 4);
    step(3); rd(A_T0, v); chk("R2 at one", v, 1);
    chk("R5 no irq before expiry", {31'd0, irq}, 0);
    step(1); rd(A_T0, v); chk("R2 reaches zero", v, 0);
    chk("R5 irq on expiry", {31'd0, irq}, 1);
    step(3); rd(A_T0, v); chk("R4 one-shot stays zero", v, 0);
    rd(A_STAT, v); chk("R5 status bit0", v, 1);
    step(1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(A_STAT, 32'h6);          // bits that are not set
    rd(A_STAT, v); chk("R6 clear of other bits leaves bit0", v, 1);
    step(1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R6 write-one clears", v, 0);
    chk("R6 irq low", {31'd0, irq}, 0);
    step(1);
  endtask

  task automatic t_autoreload;
    logic [31:0] v;
    logic [31:0] expv [7] = '{2, 1, 0, 3, 2, 1, 0};
    wr(A_CTRL, 0);
    wr(A_RL0, 3);
    wr(A_T0, 2);
    wr(A_CTRL, 32'h3);          // run timer0 with auto-reload
    for (int k = 0; k < 7; k++) begin
      rd(A_T0, v); chk("R3 reload sequence", v, expv[k]);
      if (k < 6) step(1);
    end
    step(0);
    @(negedge clk);             // realign after the last read
    // now one cycle later the reload would have landed; instead test priority on next zero
    rd(A_T0, v); chk("R3 reload after second expiry", v, 3);
    step(2);
    rd(A_T0, v); chk("R3 counting again", v, 1);
    step(1);
    rd(A_T0, v); chk("R3 third expiry", v, 0);
    wr(A_T0, 40);               // reload due on this edge; the write wins
    rd(A_T0, v); chk("R7 write beats reload", v, 40);
    chk("R5 pending0 after auto expiries", {29'd0, irq_pend}, 1);
    wr(A_CTRL, 0);
    wr(A_STAT, 32'h7);
    step(1);
  endtask

  task automatic t_aux_and_stop;
    logic [31:0] v, a;
    wr(A_T1, 100);
    wr(A_CTRL, 32'h4);
    rd(A_T1, v); chk("R2 timer1 first", v, 100);
    step(1); rd(A_T1, v); chk("R2 timer1 step", v, 99);
    step(1); rd(A_T1, v); chk("R2 timer1 step2", v, 98);
    step(1);
    wr(A_T1, 7);
    rd(A_T1, v); chk("R7 running write", v, 7);
    step(1);
    wr(A_CTRL, 0);
    rd(A_T1, a); chk("R8 last step before stop", a, 5);
    step(3); rd(A_T1, v); chk("R8 held after stop", v, a);
    step(1);
  endtask

  task automatic t_watchdog;
    logic [31:0] v;
    rst_out_en = 1'b0;
    wr(A_TW, 4);
    wr(A_CTRL, 32'h10);
    rd(A_TW, v); chk("R2 watchdog first", v, 4);
    step(2); rd(A_TW, v); chk("R2 watchdog count", v, 2);
    step(1);
    wr(A_TW, 4);                // kick
    rd(A_TW, v); chk("R7 kick restarts", v, 4);
    step(3); rd(A_TW, v); chk("R7 not expired after kick", v, 1);
    chk("R9 no request yet", {31'd0, wd_reset_req}, 0);
    step(1); rd(A_TW, v); chk("R4 watchdog zero", v, 0);
    chk("R5 watchdog pending", {29'd0, irq_pend}, 4);
    chk("R9 request gated off", {31'd0, wd_reset_req}, 0);
    rst_out_en = 1'b1; #1;
    chk("R9 request with enable", {31'd0, wd_reset_req}, 1);
    step(1);
    wr(A_STAT, 32'h4);
    chk("R9 request drops on clear", {31'd0, wd_reset_req}, 0);
    chk("R6 irq after watchdog clear", {31'd0, irq}, 0);
    rst_out_en = 1'b0;
    wr(A_CTRL, 0);
    step(1);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(A_RL1, 32'h1234_5678);
    rd(A_RL1, v); chk("R7 reload readback", v, 32'h1234_5678);
    step(1);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R10 reserved reads zero", v, 0);
    rd(A_CTRL, v); chk("R10 ctrl untouched", v, 0);
    rd(4'd11, v); chk("R10 high reserved zero", v, 0);
    step(1);
    wr(4'd13, 32'h3F);
    rd(A_CTRL, v); chk("R10 write to 13 ignored", v, 0);
    rd(A_RL1, v); chk("R10 reload1 untouched", v, 32'h1234_5678);
    step(1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_clear();
    t_autoreload();
    t_aux_and_stop();
    t_watchdog();
    t_map();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule